// File: doc/BRIEF.md
# Byte-Opcode SPI Transfer Sequencer

This block is a half-duplex SPI master. Software does not shift bytes one write at a time. It loads a small program of up to eight one-byte opcodes into a 64-bit program register. The engine runs the opcodes from the top byte down. It can drive or release a chip select, send a group of bytes from a 64-bit transmit holding register, or collect a group of bytes into a 64-bit receive holding register. A branch opcode jumps back to an earlier slot while a loop counter stays above zero, so one short program can move long streams of fixed-size chunks.

Software reaches the block through a simple write port with a 3-bit address. Address 0 holds the program, 1 the transmit data, 2 the loop configuration, 3 the clock configuration, and any write to address 4 clears the sticky error flags. Software reads the receive data through a pop strobe. A 64-bit status word reports the full flags of both holding registers, the error flags and the engine state. The shift clock is SPI mode 0, and its half period is set by a divider.

Top module: `opseq_spi_master`

## Requirements
- R1: After reset the status word reads 64'h0001_0000_0000_0000 (idle, no flags), every cs_n line is high and sck is low.
- R2: A program write (address 0) while idle starts execution at slot 0, which is bits 63:56, and then moves to lower bytes in turn. A program write while the engine is not idle is ignored.
- R3: Opcode 8'h00 returns the engine to idle. Opcodes 8'h01 to 8'h0F do nothing and execution moves to the next slot. Finishing slot 7 without a stop also returns the engine to idle.
- R4: Opcode 8'h1n with n from 1 to NCS drives cs_n[n-1] low and all other lines high. With n = 0 or n > NCS, every line is released. The selection holds until the next such opcode.
- R5: Opcode 8'h3n waits until transmit-full (status bit 59) is set. It then clears that flag and sends n bytes MSB first, starting at bits 63:56 of the transmit register. An n of 0 or above 8 sends 8 bytes.
- R6: Opcode 8'h4n receives n bytes, packed so the last byte lands in bits 7:0 with zeros above the received bytes, and then sets receive-full (bit 63). While receive-full is set it stalls and sets receive-overrun (bit 62).
- R7: A receive opcode needs a transmit-register write as its trigger and consumes it (bit 59 clears). When the implicit bit (loop configuration bit 10) is set, only the first receive opcode after a program start needs that trigger.
- R8: The loop counter is loaded from loop configuration bits 39:32 when a program starts. Opcode 8'hEn with a nonzero counter decrements it and jumps to slot n[2:0]. With a zero counter it moves to the next slot.
- R9: A transmit-register write while bit 59 is set drops the data and sets transmit-overrun (bit 58).
- R10: A pop while receive-full is set clears bit 63. A pop while it is clear sets receive-underrun (bit 61).
- R11: A write to address 4 clears bits 58, 61 and 62.
- R12: sck idles low. Each sck level lasts exactly (div+1) clocks, where div comes from clock configuration bits 63:52. mosi changes only while sck is low, and miso is sampled on the rising edge.
- R13: Status bits 55:48 read 8'h01 when idle, 8'h02 while decoding an opcode, 8'h04 while shifting and 8'h08 while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 64 | Register write data |
| rx_pop | input | 1 | Single-cycle read strobe for the receive register |
| rx_data | output | 64 | Receive holding register |
| status | output | 64 | Flags and engine state |
| sck | output | 1 | SPI shift clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
The assertions assume the following about the inputs:
- rx_pop is a one-cycle strobe.
- The clock configuration changes only while the engine is idle. This is needed because a mid-transfer change would break the per-level timing rule.
- miso is driven to a known level.

The stimulus changes the divider only after the status word reads idle. It polls the transmit-full flag before each further transmit write, except in the one step that provokes an overrun on purpose. It drives miso from a slave model that advances on falling sck edges, so miso is always defined.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  localparam logic [2:0] A_PROG  = 3'd0;
  localparam logic [2:0] A_TXD   = 3'd1;
  localparam logic [2:0] A_LOOP  = 3'd2;
  localparam logic [2:0] A_CLK   = 3'd3;
  localparam logic [2:0] A_CLEAR = 3'd4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_SHIFT} sq_state_t;

  function automatic logic [3:0] byte_count(input logic [3:0] n);
    return (n == 4'd0 || n > 4'd8) ? 4'd8 : n;
  endfunction
endpackage

// File: rtl/opseq_sck_tick.sv
module opseq_sck_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == div);
endmodule

// File: rtl/opseq_shifter.sv
module opseq_shifter #(
  parameter int DW    = 64,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rx_mode,
  input  logic [3:0]       nbytes,
  input  logic [DW-1:0]    txd,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rxd
);
  localparam int BCW = $clog2(DW + 1);

  logic          busy_q, sck_q, done_q, tick;
  logic [DW-1:0] sr_q, rsr_q;
  logic [BCW-1:0] bits_q;

  opseq_sck_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy_q), .div(div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      sr_q <= '0; rsr_q <= '0; bits_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        sr_q   <= rx_mode ? '0 : txd;
        rsr_q  <= '0;
        bits_q <= BCW'({nbytes, 3'b000});
      end else if (busy_q && tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rsr_q <= {rsr_q[DW-2:0], miso};
        end else begin
          sck_q  <= 1'b0;
          sr_q   <= {sr_q[DW-2:0], 1'b0};
          bits_q <= bits_q - 1'b1;
          if (bits_q == BCW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sck  = sck_q;
  assign mosi = sr_q[DW-1];
  assign busy = busy_q;
  assign done = done_q;
  assign rxd  = rsr_q;

  // R12
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !sck_q);
  // R12
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sck_q && $past(sck_q)) |-> $stable(mosi));
endmodule

// File: rtl/opseq_spi_master.sv
module opseq_spi_master
  import opseq_pkg::*;
#(
  parameter int NCS   = 4,
  parameter int DW    = 64,
  parameter int DIV_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           rx_pop,
  output logic [DW-1:0]  rx_data,
  output logic [63:0]    status,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  sq_state_t        st_q;
  logic [DW-1:0]    prog_q, tx_q, rx_q, sh_rxd;
  logic [2:0]       pc_q;
  logic [7:0]       loop_q, loop_cfg_q;
  logic             implicit_q, trig_q, shift_rx_q;
  logic [DIV_W-1:0] div_q;
  logic             tx_full, rx_full, tx_ovr, rx_ovr, rx_und;
  logic [3:0]       cs_sel_q;
  logic [5:0]       op_lsb;
  logic [7:0]       op;
  logic [3:0]       op_hi, op_lo;
  logic             sh_start, sh_rx, stall, step, go_idle, sh_busy, sh_done;
  logic [7:0]       state_code;

  assign op_lsb = {3'd7 - pc_q, 3'b000};
  assign op     = prog_q[op_lsb +: 8];
  assign op_hi  = op[7:4];
  assign op_lo  = op[3:0];

  always_comb begin
    sh_start = 1'b0; sh_rx = 1'b0; stall = 1'b0; step = 1'b0; go_idle = 1'b0;
    if (st_q == SQ_RUN) begin
      case (op_hi)
        4'h0: if (op_lo == 4'h0) go_idle = 1'b1; else step = 1'b1;
        4'h3: if (tx_full) sh_start = 1'b1; else stall = 1'b1;
        4'h4: if (!rx_full && (tx_full || (implicit_q && trig_q))) begin
                sh_start = 1'b1; sh_rx = 1'b1;
              end else stall = 1'b1;
        4'hE: step = (loop_q == 8'd0);
        default: step = 1'b1;
      endcase
    end
  end

  opseq_shifter #(.DW(DW), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .rx_mode(sh_rx),
    .nbytes(byte_count(op_lo)), .txd(tx_q), .div(div_q), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(sh_busy), .done(sh_done), .rxd(sh_rxd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SQ_IDLE; prog_q <= '0; pc_q <= '0; loop_q <= '0; loop_cfg_q <= '0;
      implicit_q <= 1'b0; trig_q <= 1'b0; shift_rx_q <= 1'b0; div_q <= '0;
      tx_q <= '0; rx_q <= '0; tx_full <= 1'b0; rx_full <= 1'b0;
      tx_ovr <= 1'b0; rx_ovr <= 1'b0; rx_und <= 1'b0; cs_sel_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_CLEAR) begin
        tx_ovr <= 1'b0; rx_ovr <= 1'b0; rx_und <= 1'b0;
      end
      if (reg_we && reg_addr == A_LOOP) begin
        loop_cfg_q <= reg_wdata[39:32];
        implicit_q <= reg_wdata[10];
      end
      if (reg_we && reg_addr == A_CLK) div_q <= reg_wdata[63:52];
      if (sh_start && tx_full) tx_full <= 1'b0;
      if (reg_we && reg_addr == A_TXD) begin
        if (tx_full) tx_ovr <= 1'b1;
        else begin tx_q <= reg_wdata; tx_full <= 1'b1; end
      end
      if (rx_pop) begin
        if (rx_full) rx_full <= 1'b0;
        else         rx_und  <= 1'b1;
      end
      case (st_q)
        SQ_IDLE: if (reg_we && reg_addr == A_PROG) begin
          prog_q <= reg_wdata; pc_q <= '0; st_q <= SQ_RUN;
          loop_q <= loop_cfg_q; trig_q <= 1'b0;
        end
        SQ_RUN: begin
          if (stall && op_hi == 4'h4 && rx_full) rx_ovr <= 1'b1;
          if (go_idle) st_q <= SQ_IDLE;
          else if (sh_start) begin
            st_q <= SQ_SHIFT; shift_rx_q <= sh_rx;
            if (sh_rx) trig_q <= 1'b1;
          end else if (op_hi == 4'hE && loop_q != 8'd0) begin
            loop_q <= loop_q - 1'b1; pc_q <= op_lo[2:0];
          end else if (step) begin
            if (op_hi == 4'h1) cs_sel_q <= op_lo;
            if (pc_q == 3'd7) st_q <= SQ_IDLE;
            else              pc_q <= pc_q + 1'b1;
          end
        end
        SQ_SHIFT: if (sh_done) begin
          if (shift_rx_q) begin rx_q <= sh_rxd; rx_full <= 1'b1; end
          if (pc_q == 3'd7) st_q <= SQ_IDLE;
          else begin st_q <= SQ_RUN; pc_q <= pc_q + 1'b1; end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign cs_n[k] = !(cs_sel_q == 4'(k + 1));
  end

  always_comb begin
    case (st_q)
      SQ_RUN:   state_code = stall ? 8'h08 : 8'h02;
      SQ_SHIFT: state_code = 8'h04;
      default:  state_code = 8'h01;
    endcase
  end

  assign rx_data = rx_q;
  assign status  = {rx_full, rx_ovr, rx_und, 1'b0, tx_full, tx_ovr, 2'b00,
                    state_code, 48'd0};

  // R2
  prog_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_IDLE && reg_we && reg_addr == A_PROG) |=> (st_q == SQ_RUN && pc_q == 3'd0));
  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_RUN && op == 8'h00) |=> st_q == SQ_IDLE);
  // R4
  cs_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  // R5
  tx_consume_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_full) |-> $past(st_q == SQ_RUN));
  // R6
  rx_fill_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(st_q == SQ_SHIFT && shift_rx_q && sh_done));
  // R9
  tx_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_TXD && tx_full) |=> tx_ovr);
  // R10
  rx_und_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_full) |=> rx_und);
endmodule

// File: tb/opseq_spi_master_test.sv
module opseq_spi_master_test;
  logic        clk = 1'b0, rst = 1'b1, reg_we = 1'b0, rx_pop = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, rx_data, status;
  logic        sck, mosi, miso;
  logic [3:0]  cs_n;

  int tests = 0, fails = 0, gb = 0, capn = 0, since = 0, div_model = 0;
  bit finished = 0;
  logic [7:0] capb = '0, mbyte;
  logic [7:0] cap_q[$], exp_q[$];
  logic sck_prev = 1'b0, mosi_prev = 1'b0;

  always #2 clk = ~clk;

  opseq_spi_master uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rx_pop(rx_pop), .rx_data(rx_data), .status(status), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  function automatic logic [7:0] fb(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always_comb begin
    mbyte = fb(gb >> 3);
    miso  = mbyte[7 - (gb & 7)];
  end
  always @(negedge sck) gb = gb + 1;
  always @(posedge sck) begin
    capb = {capb[6:0], mosi};
    capn = capn + 1;
    if (capn == 8) begin cap_q.push_back(capb); capn = 0; end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R12 per-clock model of the shift clock timing
  always @(negedge clk) begin
    if (!rst) begin
      since = since + 1;
      if (sck != sck_prev) begin
        if (!sck) check(since == div_model + 1, "R12 high level length", 64'(since), 64'(div_model + 1));
        else      check(since >= div_model + 1, "R12 low level length", 64'(since), 64'(div_model + 1));
        since = 0;
      end else if (sck && sck_prev) begin
        check(mosi == mosi_prev, "R12 mosi hold while sck high", 64'(mosi), 64'(mosi_prev));
      end
    end
    sck_prev  = sck;
    mosi_prev = mosi;
  end

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_state(input logic [7:0] want, input string tag);
    int n = 0;
    while (status[55:48] != want && n < 20000) begin @(negedge clk); n++; end
    check(status[55:48] == want, tag, 64'(status[55:48]), 64'(want));
  endtask

  task automatic wait_bit(input int b, input logic v, input string tag);
    int n = 0;
    while (status[b] != v && n < 20000) begin @(negedge clk); n++; end
    check(status[b] == v, tag, 64'(status[b]), 64'(v));
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_cap(input string tag);
    check(cap_q.size() == exp_q.size(), tag, 64'(cap_q.size()), 64'(exp_q.size()));
    if (cap_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        check(cap_q[i] == exp_q[i], tag, 64'(cap_q[i]), 64'(exp_q[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 R13 reset state
    check(status == 64'h0001_0000_0000_0000, "R1 status after reset", status, 64'h0001_0000_0000_0000);
    check(cs_n == 4'hF && sck == 1'b0, "R1 cs_n and sck after reset", {cs_n, 3'b0, sck}, 64'hF0);

    wr(3'd3, 64'(1) << 52); div_model = 1;

    // R5 R2 R4 R3 basic send of three bytes on cs 2
    cap_q.delete();
    wr(3'd1, 64'hA1B2C3_0000000000);
    wr(3'd0, 64'h12_33_10_00_00000000);
    @(posedge sck); #1;
    check(cs_n == 4'b1101, "R4 cs 2 selected", 64'(cs_n), 64'hD);
    wait_state(8'h01, "R3 idle after stop");
    exp_q = '{8'hA1, 8'hB2, 8'hC3};
    check_cap("R5 bytes sent MSB first");
    check(cs_n == 4'hF, "R4 released by 0x10", 64'(cs_n), 64'hF);
    check(status[59] == 1'b0, "R5 tx full consumed", 64'(status[59]), 64'h0);

    // R5 R13 stall without data, R2 write while busy ignored
    cap_q.delete();
    wr(3'd0, 64'h11_32_10_00_00000000);
    idle_clocks(20);
    check(status[55:48] == 8'h08, "R13 stalled code", 64'(status[55:48]), 64'h08);
    check(cap_q.size() == 0, "R5 nothing sent while stalled", 64'(cap_q.size()), 64'h0);
    wr(3'd0, 64'h11_31_10_00_00000000);
    wr(3'd1, 64'h5A6B_000000000000);
    wait_state(8'h01, "R2 idle after run");
    exp_q = '{8'h5A, 8'h6B};
    check_cap("R2 busy program write ignored");

    // R7 R6 receive with a trigger write
    wr(3'd2, 64'h0);
    g = gb >> 3;
    wr(3'd0, 64'h11_42_10_00_00000000);
    idle_clocks(20);
    check(status[55:48] == 8'h08, "R7 receive waits for trigger", 64'(status[55:48]), 64'h08);
    wr(3'd1, 64'h0);
    wait_state(8'h01, "R6 idle after receive");
    check(rx_data == {48'd0, fb(g), fb(g + 1)}, "R6 receive packing", rx_data, {48'd0, fb(g), fb(g + 1)});
    check(status[63] == 1'b1, "R6 receive full set", 64'(status[63]), 64'h1);
    check(status[59] == 1'b0, "R7 trigger consumed", 64'(status[59]), 64'h0);

    // R10 R11 pop and underrun
    pop();
    check(status[63] == 1'b0 && status[61] == 1'b0, "R10 pop clears full", status, 64'h0001_0000_0000_0000);
    pop();
    check(status[61] == 1'b1, "R10 underrun on empty pop", 64'(status[61]), 64'h1);
    wr(3'd4, 64'h0);
    check(status[61] == 1'b0, "R11 clear underrun", 64'(status[61]), 64'h0);

    // R8 R7 R6 implicit receive loop with full stalls
    wr(3'd2, (64'(2) << 32) | (64'(1) << 10));
    g = gb >> 3;
    wr(3'd0, 64'h11_41_E1_10_00000000);
    wr(3'd1, 64'h0);
    for (int k = 0; k < 3; k++) begin
      wait_bit(63, 1'b1, "R6 receive full in loop");
      check(rx_data == 64'(fb(g + k)), "R8 looped receive data", rx_data, 64'(fb(g + k)));
      if (k < 2) begin
        idle_clocks(10);
        check(status[62] == 1'b1 && status[55:48] == 8'h08, "R6 overrun stall",
              {status[62], status[55:48]}, 64'h108);
      end
      pop();
    end
    wait_state(8'h01, "R8 idle after loop");
    check((gb >> 3) == g + 3, "R8 three receive passes", 64'((gb >> 3) - g), 64'h3);
    wr(3'd4, 64'h0);
    check(status[62] == 1'b0, "R11 clear overrun", 64'(status[62]), 64'h0);

    // R8 send loop without implicit mode
    wr(3'd2, 64'(1) << 32);
    cap_q.delete();
    wr(3'd0, 64'h11_31_E1_10_00000000);
    wr(3'd1, 64'hC4 << 56);
    wait_bit(59, 1'b0, "R8 first chunk taken");
    wr(3'd1, 64'hD5 << 56);
    wait_state(8'h01, "R8 idle after send loop");
    exp_q = '{8'hC4, 8'hD5};
    check_cap("R8 send loop bytes");

    // R9 overrun drops data
    wr(3'd2, 64'h0);
    wr(3'd1, 64'h77 << 56);
    wr(3'd1, 64'h88 << 56);
    check(status[58] == 1'b1 && status[59] == 1'b1, "R9 overrun flagged", status, 64'h0C01_0000_0000_0000);
    cap_q.delete();
    wr(3'd0, 64'h11_31_10_00_00000000);
    wait_state(8'h01, "R9 idle");
    exp_q = '{8'h77};
    check_cap("R9 second write dropped");
    wr(3'd4, 64'h0);
    check(status[58] == 1'b0, "R11 clear tx overrun", 64'(status[58]), 64'h0);

    // R3 run past slot 7, R4 out-of-range select
    cap_q.delete();
    wr(3'd1, 64'h99 << 56);
    wr(3'd0, 64'h13_31_16_01_02_03_04_05);
    @(posedge sck); #1;
    check(cs_n == 4'b1011, "R4 cs 3 selected", 64'(cs_n), 64'hB);
    wait_state(8'h01, "R3 idle past slot 7");
    check(cs_n == 4'hF, "R4 select above NCS releases", 64'(cs_n), 64'hF);
    exp_q = '{8'h99};
    check_cap("R3 no-op opcodes skipped");

    // R12 slower divider
    wr(3'd3, 64'(3) << 52); div_model = 3;
    cap_q.delete();
    wr(3'd1, 64'hE7 << 56);
    wr(3'd0, 64'h11_31_10_00_00000000);
    wait_state(8'h01, "R12 idle with divider 3");
    exp_q = '{8'hE7};
    check_cap("R12 byte with divider 3");

    // R5 count field 0 sends eight bytes
    wr(3'd3, 64'h0); div_model = 0;
    cap_q.delete();
    wr(3'd1, 64'h0102030405060708);
    wr(3'd0, 64'h11_30_10_00_00000000);
    wait_state(8'h01, "R5 idle after eight bytes");
    exp_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    check_cap("R5 zero count means eight");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule